// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor's instruction-fetch port and a memory that returns one 32-bit word per read. Fetches in the two cacheable address banks (address bits [31:24] equal to 0x00 or 0x80) are looked up in a 4 KB direct-mapped store. A hit returns the stored word on the next cycle and makes no memory access. A miss refills the whole aligned 16-byte line, four words in ascending order, and hands the requested word to the processor as soon as it arrives. Fetches in any other bank go straight to memory as a single word read, and the store is left as it was.

Each word slot keeps its own 24-bit tag: the full low 24 bits of the word address. A flash invalidate input sets every tag and every data word to all ones. An all-ones tag can never equal a word-aligned address, so every slot reads as empty. The processor sees a request/ready handshake with a one-cycle response pulse. The memory side has a request handshake (valid/ready) and a response strobe, with one read outstanding at a time.

Top module: `fetch_dm_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. The first fetch to any cacheable address misses.
- R2: A cacheable miss issues exactly four memory reads, at the line base (fetch address with bits [3:0] cleared) plus 0, 4, 8 and 12, in that order. `rsp_valid` pulses, carrying the requested word, in the cycle after that word's memory response is taken.
- R3: A fetch to any word of a line already filled hits. `rsp_valid` rises on the clock edge that accepts the request, `req_ready` stays 1 afterwards, and no memory read is made.
- R4: Only fetches with address bits [31:24] equal to 0x00 or 0x80 are cacheable. Any other fetch makes exactly one memory read, at the fetch address with bits [1:0] cleared, returns that word, and does not fill the store. A repeat of that fetch reads memory again.
- R5: The slot is selected by address bits [11:2] and the tag is address bits [23:0]. A fetch with the same index but a different tag misses and replaces the line. Fetches in banks 0x00 and 0x80 with equal low 24 bits share a slot and hit on each other.
- R6: From the edge that accepts a missing or bypassed fetch until its last memory read completes, `req_ready` is 0.
- R7: While `inv_i` is 1, `req_ready` is 0. After an invalidate, every previously filled line misses.
- R8: An invalidate during a fill does not cut the memory traffic short: all four reads complete and the requested word is still returned. However, none of the line is kept, so the next fetch to that line misses.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` hold their values into the next cycle.
- R10: Over a random stream of fetches across cacheable and bypass banks, with index conflicts and occasional invalidates, every returned word and every memory read matches an independent model of the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_i | input | 1 | Flash invalidate of the whole store |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Fetch request accepted this cycle |
| rsp_valid | output | 1 | One-cycle pulse: fetched word valid |
| rsp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_addr | output | 32 | Word-aligned memory read address |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
Directed fetches run in a fixed order. A cold miss followed by hits to the same line separates the fill path from the hit path. A fetch from the other cacheable bank with the same low bits shows that the bank bits are left out of the tag. A fetch at the same index with a different tag shows replacement, and repeated fetches from bypass banks show that those banks leave the store alone. An invalidate is applied both while idle and in the middle of a fill, to tell a full clear apart from a fill that still installs its line. A long random stream then mixes the four banks, three conflicting index pages and random memory stalls, and each returned word and each memory read is checked against a model held in the bench.

// File: rtl/fetch_dm_cache.sv
`timescale 1ns/1ps
module fetch_dm_cache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_WORDS  = 4,
  parameter int BANK_W      = 8,
  parameter logic [BANK_W-1:0] BANK_LO = 8'h00,
  parameter logic [BANK_W-1:0] BANK_HI = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_i,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int NUM_WORDS = CACHE_BYTES / 4;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int BEAT_W    = $clog2(LINE_WORDS);
  localparam int LINE_LSB  = BEAT_W + 2;
  localparam int TAG_W     = ADDR_W - BANK_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);
  localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_t;

  state_t            state_q;
  logic [TAG_W-1:0]  tag_q  [NUM_WORDS];
  logic [DATA_W-1:0] word_q [NUM_WORDS];
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] want_q;
  logic              bypass_q;
  logic              poison_q;

  logic [ADDR_W-1:0] req_word;
  logic [BANK_W-1:0] req_bank;
  logic              cacheable;
  logic [IDX_W-1:0]  req_idx;
  logic              lookup_hit;
  logic              accept;
  logic [ADDR_W-1:0] beat_addr;
  logic [IDX_W-1:0]  beat_idx;
  logic              beat_done;
  logic              beat_last;
  logic              install;

  assign req_word   = req_addr & WORD_MASK;
  assign req_bank   = req_word[ADDR_W-1 -: BANK_W];
  assign cacheable  = (req_bank == BANK_LO) || (req_bank == BANK_HI);
  assign req_idx    = req_word[IDX_W+1:2];
  assign lookup_hit = cacheable && (tag_q[req_idx] == req_word[TAG_W-1:0]);
  assign accept     = req_valid && req_ready;

  assign beat_addr  = bypass_q ? base_q : {base_q[ADDR_W-1:LINE_LSB], beat_q, 2'b00};
  assign beat_idx   = beat_addr[IDX_W+1:2];
  assign beat_done  = (state_q == ST_WAIT) && mem_rsp_valid;
  assign beat_last  = bypass_q || (beat_q == LAST_BEAT);
  assign install    = beat_done && !bypass_q && !poison_q;

  assign req_ready     = (state_q == ST_IDLE) && !inv_i;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = beat_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      beat_q    <= '0;
      want_q    <= '0;
      bypass_q  <= 1'b0;
      poison_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (lookup_hit) begin
              rsp_valid <= 1'b1;
              rsp_data  <= word_q[req_idx];
            end else begin
              state_q  <= ST_ISSUE;
              base_q   <= req_word;
              beat_q   <= '0;
              want_q   <= req_word[LINE_LSB-1:2];
              bypass_q <= !cacheable;
              poison_q <= 1'b0;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (bypass_q || (beat_q == want_q)) begin
              rsp_valid <= 1'b1;
              rsp_data  <= mem_rsp_data;
            end
            if (beat_last) begin
              state_q <= ST_IDLE;
            end else begin
              beat_q  <= beat_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (inv_i && (state_q != ST_IDLE)) poison_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        tag_q[i]  <= '1;
        word_q[i] <= '1;
      end
    end else if (inv_i) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        tag_q[i]  <= '1;
        word_q[i] <= '1;
      end
    end else if (install) begin
      tag_q[beat_idx]  <= beat_addr[TAG_W-1:0];
      word_q[beat_idx] <= mem_rsp_data;
    end
  end
endmodule

// File: rtl/fetch_dm_cache_chk.sv
`timescale 1ns/1ps
module fetch_dm_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_i,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_ready,
  input logic              mem_rsp_valid
);
  p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_busy_blocks_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_invalidate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |-> !req_ready);

  p_aligned_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R2 / R3: a response follows either an accepted hit or a memory beat
  p_rsp_has_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready) || $past(mem_rsp_valid));
endmodule

bind fetch_dm_cache fetch_dm_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .inv_i         (inv_i),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_req_ready (mem_req_ready),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/fetch_dm_cache_tb_top.sv
`timescale 1ns/1ps
module fetch_dm_cache_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_BYP = 2'd2;

  typedef struct packed {
    logic [31:0] data;
    logic [31:0] waddr;
    logic [1:0]  kind;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_i = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int acc_cyc = 0;
  item_t       exp_q [$];
  logic [31:0] rd_log [$];
  logic [23:0] rtag [1024];
  logic [31:0] rdat [1024];
  bit          prev_on = 0;
  logic [31:0] prev_addr = '0;

  fetch_dm_cache dut_i (
    .clk(clk), .rst_n(rst_n), .inv_i(inv_i),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) begin
      rtag[i] = 24'hFF_FFFF;
      rdat[i] = 32'hFFFF_FFFF;
    end
  endtask

  // memory model: random request stalls, 0..2 cycles of read latency
  initial begin
    bit          fire = 0;
    logic [31:0] fire_addr = '0;
    bit          busy = 0;
    int          cnt = 0;
    logic [31:0] raddr = '0;
    bit          rsp_on = 0;
    logic [31:0] rsp_addr = '0;
    bit          hold = 0;
    logic [31:0] hold_addr = '0;
    forever begin
      @(negedge clk);
      prev_on   = rsp_on;
      prev_addr = rsp_addr;
      rsp_on    = 0;
      if (hold) chk(mem_req_valid && mem_req_addr == hold_addr, "R9",
                    "stalled request changed", mem_req_addr, hold_addr);
      if (fire) begin
        fire = 0;
        rd_log.push_back(fire_addr);
        busy  = 1;
        cnt   = $urandom_range(0, 2);
        raddr = fire_addr;
      end
      if (busy) begin
        if (cnt == 0) begin
          rsp_on = 1; rsp_addr = raddr; busy = 0;
        end else cnt--;
      end
      mem_req_ready = mem_req_valid && ($urandom_range(0, 2) != 0);
      fire      = mem_req_valid && mem_req_ready;
      fire_addr = mem_req_addr;
      hold      = mem_req_valid && !mem_req_ready;
      hold_addr = mem_req_addr;
      mem_rsp_valid = rsp_on;
      mem_rsp_data  = memf(rsp_addr);
    end
  end

  // monitor: pops expected responses
  initial begin
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected response", rsp_data, 32'h0);
        end else begin
          it = exp_q.pop_front();
          if (it.kind == K_HIT) begin
            chk(rsp_data == it.data, "R3", "hit data", rsp_data, it.data);
            chk(cyc == acc_cyc, "R3", "hit latency", cyc, acc_cyc);
          end else begin
            chk(rsp_data == it.data, it.kind == K_BYP ? "R4" : "R2", "fetched data", rsp_data, it.data);
            chk(prev_on && prev_addr == it.waddr, "R2", "response after its beat", prev_addr, it.waddr);
          end
        end
      end
    end
  end

  task automatic inv_pulse();
    @(negedge clk);
    inv_i = 1;
    model_clear();
    #1 chk(!req_ready, "R7", "ready during invalidate", req_ready, 0);
    @(negedge clk);
    inv_i = 0;
  endtask

  task automatic fetch(input logic [31:0] a, input string req, input int inv_after);
    logic [31:0] ex_rd [$];
    item_t       it;
    logic [9:0]  ix;
    logic [7:0]  bk;
    logic [31:0] base;
    bit          acc;
    bk = a[31:24];
    ix = a[11:2];
    it.waddr = {a[31:2], 2'b00};
    if ((bk == 8'h00 || bk == 8'h80) && rtag[ix] == it.waddr[23:0]) begin
      it.kind = K_HIT; it.data = rdat[ix];
    end else if (bk == 8'h00 || bk == 8'h80) begin
      it.kind = K_MISS; it.data = memf(it.waddr);
      base = {a[31:4], 4'h0};
      for (int k = 0; k < 4; k++) begin
        logic [31:0] w;
        w = base + 32'(k * 4);
        ex_rd.push_back(w);
        rtag[w[11:2]] = w[23:0];
        rdat[w[11:2]] = memf(w);
      end
    end else begin
      it.kind = K_BYP; it.data = memf(it.waddr);
      ex_rd.push_back(it.waddr);
    end
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    forever begin
      #1 acc = req_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    acc_cyc = cyc;
    #1;
    if (it.kind == K_HIT) chk(req_ready, "R3", "ready after hit", req_ready, 1);
    else chk(!req_ready, "R6", "ready while filling", req_ready, 0);
    if (inv_after > 0) begin
      repeat (inv_after) @(negedge clk);
      inv_i = 1;
      model_clear();
      #1 chk(!req_ready, "R7", "ready during invalidate", req_ready, 0);
      @(negedge clk);
      inv_i = 0;
    end
    do begin @(negedge clk); #3; end while (exp_q.size() != 0 || !req_ready);
    chk(rd_log.size() == ex_rd.size(), req, "memory read count", rd_log.size(), ex_rd.size());
    if (rd_log.size() == ex_rd.size())
      for (int k = 0; k < ex_rd.size(); k++)
        chk(rd_log[k] == ex_rd[k], req, "memory read address", rd_log[k], ex_rd[k]);
    rd_log.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog expired", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready,      "R1", "reset ready",     req_ready, 1);
    chk(!rsp_valid,     "R1", "reset response",  rsp_valid, 0);
    chk(!mem_req_valid, "R1", "reset mem valid", mem_req_valid, 0);

    fetch(32'h0000_0104, "R1", 0);
    fetch(32'h0000_010C, "R3", 0);
    fetch(32'h0000_0100, "R3", 0);
    fetch(32'h8000_0108, "R5", 0);
    fetch(32'h0000_1104, "R5", 0);
    fetch(32'h0000_0104, "R5", 0);
    fetch(32'h8000_0FF8, "R2", 0);
    fetch(32'h0000_0FF0, "R5", 0);
    fetch(32'h1F00_0200, "R4", 0);
    fetch(32'h1F00_0200, "R4", 0);
    fetch(32'hBFC0_0184, "R4", 0);
    fetch(32'h0000_0200, "R2", 0);
    inv_pulse();
    fetch(32'h0000_0104, "R7", 0);
    fetch(32'h0000_0200, "R7", 0);
    fetch(32'h0000_0308, "R8", 1);
    fetch(32'h0000_0300, "R8", 0);
    fetch(32'h0000_030C, "R8", 0);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      case ($urandom_range(0, 3))
        0: a[31:24] = 8'h00;
        1: a[31:24] = 8'h80;
        2: a[31:24] = 8'hA0;
        default: a[31:24] = 8'h1F;
      endcase
      a[23:0] = (24'($urandom_range(0, 2)) << 12) | (24'($urandom_range(0, 7)) << 4)
              | (24'($urandom_range(0, 3)) << 2);
      if ($urandom_range(0, 39) == 0) inv_pulse();
      fetch(a, "R10", ($urandom_range(0, 29) == 0) ? 1 : 0);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule